// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-visible register file of a single descriptor-driven DMA/XOR channel. A 32-bit register bus reaches four words in it. The control word turns the channel on or off and asks the engine to resume a chain. The status word reports the engine's live busy state and collects events into flags that stay set until software clears them. Two descriptor address words complete the map: one holds the descriptor the engine is running now, and one holds the pointer to the next descriptor.

The descriptor engine sits beside the block. It receives a level enable, a one-cycle append pulse and the next-descriptor pointer. It returns a busy level, six event strobes (end of transfer, end of chain and four error kinds) and a load strobe with the address of the descriptor it has just started. The block raises one interrupt line while the channel is enabled and any event flag is set. Writes take effect on the clock edge. Reads are combinational from the registered state, except busy, which is read live.

Top module: `dma_chan_regs`

## Requirements
- R1: Byte offset 0x00 is the control word. Bit 0 is the enable. A write stores it, it reads back in bit 0, and it drives `chan_en` from the edge that takes the write. Reset clears it.
- R2: Writing 1 to control bit 1 drives `append_pulse` high for exactly the one cycle after the write edge. The bit always reads back 0. The same write still updates the enable from bit 0.
- R3: Status bit 13 (offset 0x04) shows `eng_busy` live and is read-only. Writing 1 to it changes nothing.
- R4: Status bit 12 is set by `eng_evt[0]` (end of transfer) and bit 11 by `eng_evt[1]` (end of chain). Each stays set until a status write with a 1 in that bit position. Writing 0 leaves it unchanged.
- R5: Status bits 9, 5, 4 and 3 are set by `eng_evt[2]` (internal parity), `eng_evt[3]` (memory controller abort), `eng_evt[4]` (internal target abort) and `eng_evt[5]` (internal master abort). They stay set until cleared by writing 1, and each clears independently of the others.
- R6: If an event strobe and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R7: Offset 0x08 reads the current-descriptor address, captured from `eng_cur_desc` on each cycle `eng_desc_load` is high. Bus writes to 0x08 are ignored.
- R8: Offset 0x24 is the next-descriptor address. All 32 bits can be read and written, and it drives `next_desc`.
- R9: `irq` is high exactly when the enable is 1 and at least one of the six event flags is set.
- R10: Reset clears the control word, every event flag and both descriptor addresses. Reads at offsets outside the four words return 0, and all status bits other than 13, 12, 11, 9, 5 and 4..3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| eng_busy | input | 1 | Engine is processing descriptors |
| eng_evt | input | 6 | Event strobes: [0] end of transfer, [1] end of chain, [2] parity, [3] memory abort, [4] target abort, [5] master abort |
| eng_desc_load | input | 1 | Engine started a new descriptor |
| eng_cur_desc | input | 32 | Address of that descriptor |
| chan_en | output | 1 | Channel enable level |
| append_pulse | output | 1 | One-cycle request to re-read the next pointer |
| next_desc | output | 32 | Next-descriptor pointer |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs every event flag with the enable both off and on, and checks the whole status word each time. A leak between flags, or a wrong bit position, shows up as a stray or missing bit. It clears each flag both with the other flags' bits and with its own, so a design that cleared on any status write, or cleared by writing 0, leaves the wrong set of bits. A clear that meets an event in the same cycle must leave the flag set; a design that gave the clear priority would drop the event. The append bit is checked for a pulse of exactly one cycle and a readback of 0. Writes to the busy bit and to the current-descriptor word are checked for having no effect, and walking patterns catch stuck or swapped bits in the descriptor words.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int DW   = 32;
    localparam int AW   = 8;
    localparam int NEVT = 6;

    localparam logic [AW-1:0] OFS_CTRL = 8'h00;
    localparam logic [AW-1:0] OFS_STAT = 8'h04;
    localparam logic [AW-1:0] OFS_CUR  = 8'h08;
    localparam logic [AW-1:0] OFS_NEXT = 8'h24;

    localparam int EN_POS   = 0;
    localparam int APP_POS  = 1;
    localparam int BUSY_POS = 13;

    // status bit position of each engine event, index = eng_evt bit
    localparam int EVT_POS [NEVT] = '{12, 11, 9, 5, 4, 3};

    typedef struct packed {
        logic en;
        logic append;
    } ctrl_state_t;

    typedef struct packed {
        logic [NEVT-1:0] flags;
    } stat_state_t;

    typedef struct packed {
        logic [DW-1:0] cur;
        logic [DW-1:0] nxt;
    } desc_state_t;
endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
    import dcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output logic          en,
    output logic          append
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.append = 1'b0;
        if (wr_ctrl) begin
            st_d.en     = wdata[EN_POS];
            st_d.append = wdata[APP_POS];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign append = st_q.append;

    // R2: a pulse only ever follows a write carrying the append bit
    a_r2_append_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        append |-> ($past(rst_n) && $past(wr_ctrl) && $past(wdata[APP_POS])));

    // R1: the enable follows the written bit
    a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_ctrl)) |-> (en == $past(wdata[EN_POS])));
endmodule

// File: rtl/dcr_status.sv
module dcr_status
    import dcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stat,
    input  logic [DW-1:0]   wdata,
    input  logic [NEVT-1:0] evt,
    output logic [NEVT-1:0] flags
);
    stat_state_t     st_d, st_q;
    logic [NEVT-1:0] clr;

    for (genvar i = 0; i < NEVT; i++) begin : g_clr
        assign clr[i] = wr_stat & wdata[EVT_POS[i]];
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    // R6: an event always leaves its flag set, even against a clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(evt) != '0)) |-> ((flags & $past(evt)) == $past(evt)));

    // R4: a flag rises only through an event
    a_r4_set_by_event: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(evt) == '0)) |-> ((flags & ~$past(flags)) == '0));

    // R5: with no status write and no event, flags hold
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_stat) && ($past(evt) == '0)) |-> $stable(flags));
endmodule

// File: rtl/dcr_desc.sv
module dcr_desc
    import dcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_next,
    input  logic [DW-1:0] wdata,
    input  logic          load_cur,
    input  logic [DW-1:0] cur_in,
    output logic [DW-1:0] cur,
    output logic [DW-1:0] nxt
);
    desc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_next)  st_d.nxt = wdata;
        if (load_cur) st_d.cur = cur_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur = st_q.cur;
    assign nxt = st_q.nxt;

    // R7: the current address changes only on an engine load
    a_r7_cur_only_engine: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_cur)) |-> $stable(cur));

    // R8: the next pointer changes only on a bus write
    a_r8_next_only_bus: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_next)) |-> $stable(nxt));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            eng_busy,
    input  logic [NEVT-1:0] eng_evt,
    input  logic            eng_desc_load,
    input  logic [DW-1:0]   eng_cur_desc,
    output logic            chan_en,
    output logic            append_pulse,
    output logic [DW-1:0]   next_desc,
    output logic            irq
);
    logic            wr_ctrl, wr_stat, wr_next;
    logic [NEVT-1:0] flags;
    logic [DW-1:0]   cur_q, nxt_q, stat_word;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_next = bus_wr && (bus_addr == OFS_NEXT);

    dcr_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl),
        .wdata  (bus_wdata),
        .en     (chan_en),
        .append (append_pulse)
    );

    dcr_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stat(wr_stat),
        .wdata  (bus_wdata),
        .evt    (eng_evt),
        .flags  (flags)
    );

    dcr_desc u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_next (wr_next),
        .wdata   (bus_wdata),
        .load_cur(eng_desc_load),
        .cur_in  (eng_cur_desc),
        .cur     (cur_q),
        .nxt     (nxt_q)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[BUSY_POS] = eng_busy;
        for (int i = 0; i < NEVT; i++) stat_word[EVT_POS[i]] = flags[i];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[EN_POS] = chan_en;
            OFS_STAT: bus_rdata = stat_word;
            OFS_CUR:  bus_rdata = cur_q;
            OFS_NEXT: bus_rdata = nxt_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign next_desc = nxt_q;
    assign irq       = chan_en && (flags != '0);

    // R9: no interrupt while the channel is disabled
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> chan_en);

    // R2: the control word never reads the append bit back
    a_r2_append_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[APP_POS] == 1'b0));
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0;
    logic [5:0]  eng_evt = '0;
    logic        eng_desc_load = 1'b0;
    logic [31:0] eng_cur_desc = '0;
    logic        chan_en, append_pulse, irq;
    logic [31:0] next_desc;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int pos [6] = '{12, 11, 9, 5, 4, 3};

    always #10 clk = ~clk;

    dma_chan_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
        .eng_evt(eng_evt), .eng_desc_load(eng_desc_load),
        .eng_cur_desc(eng_cur_desc), .chan_en(chan_en),
        .append_pulse(append_pulse), .next_desc(next_desc), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic evt(logic [5:0] e);
        @(negedge clk); eng_evt = e;
        @(negedge clk); eng_evt = '0;
    endtask

    function automatic logic [31:0] sw(logic [5:0] f, logic b);
        logic [31:0] w = '0;
        w[13] = b;
        for (int i = 0; i < 6; i++) w[pos[i]] = f[i];
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog got=timeout exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        rd(8'h00, d); chk("R10 ctrl reset", d, 0);
        rd(8'h04, d); chk("R10 stat reset", d, 0);
        rd(8'h08, d); chk("R10 cur reset", d, 0);
        rd(8'h24, d); chk("R10 next reset", d, 0);
        chk("R10 irq reset", {31'b0, irq}, 0);
        for (int a = 0; a < 256; a += 4) begin
            if (a != 0 && a != 4 && a != 8 && a != 'h24) begin
                rd(8'(a), d); chk("R10 unmapped read", d, 0);
            end
        end

        // R1 enable
        wr(8'h00, 32'h1);
        rd(8'h00, d); chk("R1 enable readback", d, 1);
        chk("R1 chan_en", {31'b0, chan_en}, 1);
        wr(8'h00, 32'h0);
        chk("R1 disable", {31'b0, chan_en}, 0);

        // R2 append pulse, enable still updated
        wr(8'h00, 32'h3);
        chk("R2 pulse high", {31'b0, append_pulse}, 1);
        rd(8'h00, d); chk("R2 reads zero", d, 1);
        chk("R2 enable with append", {31'b0, chan_en}, 1);
        @(negedge clk);
        chk("R2 pulse one cycle", {31'b0, append_pulse}, 0);
        wr(8'h00, 32'h2);
        chk("R2 pulse no enable", {31'b0, append_pulse}, 1);
        chk("R2 enable cleared", {31'b0, chan_en}, 0);
        @(negedge clk);
        chk("R2 pulse dropped", {31'b0, append_pulse}, 0);

        // R3 busy live and read-only
        eng_busy = 1'b1;
        rd(8'h04, d); chk("R3 busy live", d, sw(0, 1));
        eng_busy = 1'b0;
        rd(8'h04, d); chk("R3 busy low", d, 0);
        wr(8'h04, 32'h2000);
        rd(8'h04, d); chk("R3 busy write ignored", d, 0);

        // R4 R5 R9 sweep over each flag and enable
        for (int en = 0; en < 2; en++) begin
            wr(8'h00, 32'(en));
            for (int k = 0; k < 6; k++) begin
                evt(6'(1 << k));
                rd(8'h04, d); chk(k < 2 ? "R4 flag set" : "R5 flag set", d, sw(6'(1 << k), 0));
                chk("R9 irq", {31'b0, irq}, 32'(en));
                wr(8'h04, 32'h0);
                rd(8'h04, d); chk("R4 write zero holds", d, sw(6'(1 << k), 0));
                wr(8'h04, ~(32'h1 << pos[k]));
                rd(8'h04, d); chk(k < 2 ? "R4 other clears" : "R5 other clears", d, sw(6'(1 << k), 0));
                wr(8'h04, 32'h1 << pos[k]);
                rd(8'h04, d); chk(k < 2 ? "R4 w1c" : "R5 w1c", d, 0);
                chk("R9 irq off", {31'b0, irq}, 0);
            end
        end

        // R5 independent clears with all set
        evt(6'h3f);
        rd(8'h04, d); chk("R5 all set", d, sw(6'h3f, 0));
        wr(8'h04, 32'h1 << 9);
        rd(8'h04, d); chk("R5 parity only cleared", d, sw(6'h3b, 0));
        wr(8'h04, 32'hffff_ffff);
        rd(8'h04, d); chk("R5 all cleared", d, 0);

        // R6 event beats clear
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bus_addr = 8'h04; bus_wr = 1'b1; bus_wdata = 32'h1 << pos[k];
            eng_evt = 6'(1 << k);
            @(negedge clk);
            bus_wr = 1'b0; eng_evt = '0;
            rd(8'h04, d); chk("R6 event wins", d, sw(6'(1 << k), 0));
            wr(8'h04, 32'h1 << pos[k]);
        end

        // R7 current descriptor
        @(negedge clk); eng_desc_load = 1'b1; eng_cur_desc = 32'hA5A5_1230;
        @(negedge clk); eng_desc_load = 1'b0; eng_cur_desc = 32'hFFFF_FFFF;
        rd(8'h08, d); chk("R7 captured", d, 32'hA5A5_1230);
        @(negedge clk);
        rd(8'h08, d); chk("R7 holds without load", d, 32'hA5A5_1230);
        wr(8'h08, 32'h1234_5678);
        rd(8'h08, d); chk("R7 write ignored", d, 32'hA5A5_1230);

        // R8 next descriptor walking bits
        for (int b = 0; b < 32; b++) begin
            wr(8'h24, 32'h1 << b);
            rd(8'h24, d); chk("R8 walk", d, 32'h1 << b);
            chk("R8 port", next_desc, 32'h1 << b);
        end
        wr(8'h24, 32'hDEAD_BEE0);
        rd(8'h24, d); chk("R8 pattern", d, 32'hDEAD_BEE0);

        // R10 reset clears everything again
        wr(8'h00, 32'h1);
        evt(6'h21);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'h04, d); chk("R10 stat after reset", d, 0);
        rd(8'h24, d); chk("R10 next after reset", d, 0);
        rd(8'h08, d); chk("R10 cur after reset", d, 0);
        chk("R10 en after reset", {31'b0, chan_en}, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule